// File: doc/BRIEF.md
# Cascadable Loadable Synchronous Counter

This block is a synchronous binary up-counter built from identical 4-bit stages. Every stage responds on the rising clock edge to a small set of actions, in a fixed priority order: clear, then parallel load, then increment, then hold. Clear and load are active-low. Two active-high enables gate counting. The first enable, `cnt_en`, is shared by every stage. The second, `chain_en`, is the cascade link, and it alone gates the stage's terminal-count flag.

The top module chains four stages into a 16-bit counter. Each stage's chain enable comes from the terminal-count flag of the stage below it. The lowest stage takes the external `chain_en` pin. Clock, clear, load and `cnt_en` are shared by all stages. A stage therefore advances only when every stage below it holds all ones. The final terminal-count flag is brought out as `carry_out`, so that wider counters can be built from several of these blocks.

All inputs and outputs are plain control and data pins. The count is always valid and there is no handshake or back-pressure.

Top module: `cascade_counter`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, `count` becomes 0, whatever the values of `ld_n`, `cnt_en`, `chain_en` and `ld_val`.
- R2: When `clr_n` is 1 and `ld_n` is 0 at a rising edge, `count` takes the value of `ld_val`, whatever the two enables are.
- R3: When `clr_n` and `ld_n` are both 1 and `cnt_en` and `chain_en` are both 1 at a rising edge, `count` increases by one.
- R4: When `clr_n` and `ld_n` are both 1 and either `cnt_en` or `chain_en` is 0 at a rising edge, `count` keeps its value.
- R5: While `chain_en` is 0, `carry_out` is 0.
- R6: `carry_out` is 1 exactly when `count` is all ones (0xFFFF) and `chain_en` is 1. `cnt_en` has no effect on it.
- R7: An increment from 0xFFFF gives 0x0000.
- R8: Each 4-bit stage advances only when all stages below it hold 0xF. For example, an increment from 0x00FF gives 0x0100 and an increment from 0x0FFF gives 0x1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable shared by all stages |
| chain_en | input | 1 | Cascade enable of the lowest stage; also gates `carry_out` |
| ld_val | input | 16 | Parallel load value |
| count | output | 16 | Current count |
| carry_out | output | 1 | Terminal-count flag of the top stage |

## Verification
Clear, load and increment can all be requested in the same cycle. The bench provokes every overlap by driving `clr_n` low together with `ld_n` low and both enables high, and by driving `ld_n` low while both enables are high. Each such cycle is judged against a priority-ordered reference model in the bench, so only the highest-ranked action may show in the next count. Increment and carry also coincide at the stage boundaries 0x00FF, 0x0FFF and 0xFFFF. Those cases are checked for the next count and for the value of `carry_out` with `cnt_en` both high and low.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_INC   = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } ctr_act_e;
endpackage

// File: rtl/ctr_act_dec.sv
module ctr_act_dec
  import cascade_counter_pkg::*;
(
  input  logic     clr_n,
  input  logic     ld_n,
  input  logic     cnt_en,
  input  logic     chain_en,
  output ctr_act_e act
);
  // Fixed priority: clear, then load, then increment, else hold.
  always_comb begin
    if (!clr_n)                  act = ACT_CLEAR;
    else if (!ld_n)              act = ACT_LOAD;
    else if (cnt_en && chain_en) act = ACT_INC;
    else                         act = ACT_HOLD;
  end
endmodule

// File: rtl/ctr_stage.sv
module ctr_stage
  import cascade_counter_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic         cnt_en,
  input  logic         chain_en,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q,
  output logic         tc
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  ctr_act_e act;

  ctr_act_dec u_dec (
    .clr_n    (clr_n),
    .ld_n     (ld_n),
    .cnt_en   (cnt_en),
    .chain_en (chain_en),
    .act      (act)
  );

  always_ff @(posedge clk) begin
    unique case (act)
      ACT_CLEAR: q <= '0;
      ACT_LOAD:  q <= ld_val;
      ACT_INC:   q <= q + 1'b1;
      default:   q <= q;
    endcase
  end

  // Terminal count is gated by the cascade enable only.
  assign tc = chain_en && (q == ALL_ONES);
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int STAGE_W  = 4,
  parameter int N_STAGES = 4
) (
  input  logic                          clk,
  input  logic                          clr_n,
  input  logic                          ld_n,
  input  logic                          cnt_en,
  input  logic                          chain_en,
  input  logic [STAGE_W*N_STAGES-1:0]   ld_val,
  output logic [STAGE_W*N_STAGES-1:0]   count,
  output logic                          carry_out
);
  localparam int TOT_W = STAGE_W * N_STAGES;

  logic [N_STAGES:0] link;

  assign link[0] = chain_en;

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    ctr_stage #(.W(STAGE_W)) u_stage (
      .clk      (clk),
      .clr_n    (clr_n),
      .ld_n     (ld_n),
      .cnt_en   (cnt_en),
      .chain_en (link[s]),
      .ld_val   (ld_val[s*STAGE_W +: STAGE_W]),
      .q        (count[s*STAGE_W +: STAGE_W]),
      .tc       (link[s+1])
    );
  end

  assign carry_out = link[N_STAGES];
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
  parameter int TOT_W = 16
) (
  input logic             clk,
  input logic             clr_n,
  input logic             ld_n,
  input logic             cnt_en,
  input logic             chain_en,
  input logic [TOT_W-1:0] ld_val,
  input logic [TOT_W-1:0] count,
  input logic             carry_out
);
  // R1: the cycle after a clear shows zero
  p_clear_r1: assert property (@(posedge clk) disable iff (!clr_n)
    $past(!clr_n) |-> count == '0);

  // R2: load wins over counting
  p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_n |=> count == $past(ld_val));

  // R3 and R7: increment with wrap
  p_inc_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && cnt_en && chain_en) |=> count == TOT_W'($past(count) + 1'b1));

  // R4: either enable low holds the count
  p_hold_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && !(cnt_en && chain_en)) |=> $stable(count));

  // R5: cascade enable low forces carry low
  p_carry_gate_r5: assert property (@(posedge clk) disable iff (!clr_n)
    !chain_en |-> !carry_out);

  // R6: carry only at full count
  p_carry_full_r6: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out |-> (count == {TOT_W{1'b1}}));
endmodule

bind cascade_counter cascade_counter_chk #(.TOT_W(STAGE_W*N_STAGES)) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .ld_n      (ld_n),
  .cnt_en    (cnt_en),
  .chain_en  (chain_en),
  .ld_val    (ld_val),
  .count     (count),
  .carry_out (carry_out)
);

// File: tb/tb_cascade_counter.sv
`timescale 1ns/1ps
module tb_cascade_counter;
  logic        clk = 1'b0;
  logic        clr_n, ld_n, cnt_en, chain_en;
  logic [15:0] ld_val;
  logic [15:0] count;
  logic        carry_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_cnt;

  always #5 clk = ~clk;

  cascade_counter dut (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .cnt_en(cnt_en),
    .chain_en(chain_en), .ld_val(ld_val), .count(count), .carry_out(carry_out)
  );

  task automatic check_val(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle, update the reference model, check count and carry after the edge.
  task automatic step(input string tag, input logic c, input logic l,
                      input logic ce, input logic te, input logic [15:0] d);
    @(negedge clk);
    clr_n = c; ld_n = l; cnt_en = ce; chain_en = te; ld_val = d;
    if (!c)            exp_cnt = 16'h0000;
    else if (!l)       exp_cnt = d;
    else if (ce && te) exp_cnt = exp_cnt + 16'h0001;
    @(posedge clk);
    #2;
    check_val({tag, " count"}, count, exp_cnt);
    check_val({tag, " carry"}, {15'd0, carry_out},
              {15'd0, (exp_cnt == 16'hFFFF) && te});
  endtask

  task automatic t_reset();
    step("R1 reset", 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000);
    step("R1 reset hold", 1'b1, 1'b1, 1'b0, 1'b1, 16'h0000);
  endtask

  task automatic t_load();
    step("R2 load a", 1'b1, 1'b0, 1'b0, 1'b0, 16'hA5C3);
    step("R2 load b", 1'b1, 1'b0, 1'b1, 1'b1, 16'h1234);
  endtask

  task automatic t_count();
    for (int i = 0; i < 20; i++) step("R3 count", 1'b1, 1'b1, 1'b1, 1'b1, 16'h0);
  endtask

  task automatic t_hold();
    step("R4 hold cnt_en low", 1'b1, 1'b1, 1'b0, 1'b1, 16'hFFFF);
    step("R4 hold chain_en low", 1'b1, 1'b1, 1'b1, 1'b0, 16'hFFFF);
    step("R4 hold both low", 1'b1, 1'b1, 1'b0, 1'b0, 16'hFFFF);
  endtask

  task automatic t_priority();
    step("R1 clear over load", 1'b0, 1'b0, 1'b1, 1'b1, 16'hBEEF);
    step("R2 load over count", 1'b1, 1'b0, 1'b1, 1'b1, 16'h0F0F);
    step("R1 clear over count", 1'b0, 1'b1, 1'b1, 1'b1, 16'h7777);
  endtask

  task automatic t_carry();
    step("R8 preload 00FE", 1'b1, 1'b0, 1'b0, 1'b0, 16'h00FE);
    step("R8 to 00FF", 1'b1, 1'b1, 1'b1, 1'b1, 16'h0);
    step("R8 00FF to 0100", 1'b1, 1'b1, 1'b1, 1'b1, 16'h0);
    step("R8 preload 0FFF", 1'b1, 1'b0, 1'b0, 1'b1, 16'h0FFF);
    step("R8 0FFF to 1000", 1'b1, 1'b1, 1'b1, 1'b1, 16'h0);
    step("R7 preload FFFE", 1'b1, 1'b0, 1'b0, 1'b1, 16'hFFFE);
    step("R7 to FFFF", 1'b1, 1'b1, 1'b1, 1'b1, 16'h0);
    step("R7 wrap to 0000", 1'b1, 1'b1, 1'b1, 1'b1, 16'h0);
  endtask

  task automatic t_carry_gate();
    step("R6 full count cnt_en low", 1'b1, 1'b0, 1'b0, 1'b1, 16'hFFFF);
    step("R6 carry without cnt_en", 1'b1, 1'b1, 1'b0, 1'b1, 16'h0);
    step("R5 chain_en low gates carry", 1'b1, 1'b1, 1'b1, 1'b0, 16'h0);
    step("R6 not full no carry", 1'b1, 1'b0, 1'b0, 1'b1, 16'hFFFE);
  endtask

  initial begin
    clr_n = 1'b0; ld_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b0; ld_val = '0;
    exp_cnt = '0;
    t_reset();
    t_load();
    t_count();
    t_hold();
    t_priority();
    t_carry();
    t_carry_gate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule